// File: doc/BRIEF.md
# Mains-Rate Timekeeping Tick and Countdown Echo

This block turns a slow pulse train derived from the AC supply (50 Hz or 60 Hz) into timekeeping interrupts. The line pulse is brought into the clock domain through a flop synchronizer, and its edges are converted into single-cycle tick requests. A rate input chooses between one tick per line period (rising edges only) and two ticks per line period (rising and falling edges).

Each tick stands for the service of a timekeeping interrupt, and that service counts a signed preset value down by one. A second decrement input models countdowns issued by other code paths. When the count steps from zero to minus one, the block pulses an echo output to mark that the programmed interval has run out. It raises a follow-on interrupt request only when the step that crossed zero came from a tick. Software then writes a fresh interval through the reload port.

Top module: `linetick_countdown`

## Requirements
- R1: While reset is asserted and after its release, `tick_irq`, `echo` and `echo_irq` are 0 and `count_o` is 0.
- R2: A change on `line_in` passes through a two-stage synchronizer. A qualifying change made between clock edges shows on `tick_irq` for exactly one cycle, starting at the third rising clock edge after the change.
- R3: With `rate_double` = 0, only a 0-to-1 change of `line_in` produces a tick. A 1-to-0 change produces neither a tick nor a change of `count_o`.
- R4: With `rate_double` = 1, both a 0-to-1 and a 1-to-0 change of `line_in` produce a tick.
- R5: Each tick decrements `count_o` by one, and the new count is visible in the same cycle that `tick_irq` is high. `count_o` is a two's complement signed value.
- R6: A cycle with `ext_dec` high decrements `count_o` by one at the next clock edge. When a tick and `ext_dec` fall in the same cycle, the count drops by one only, and that step is treated as tick-caused.
- R7: `reload_stb` loads `reload_val` into `count_o` at the next edge and overrides any decrement in the same cycle. Such a cycle produces no echo.
- R8: `echo` pulses for one cycle, together with the updated count, when a decrement takes the count from 0 to -1, whatever its source. Further decrements below -1 produce no echo.
- R9: `echo_irq` pulses with `echo` only when the decrement that crossed zero was caused by a tick. An `ext_dec`-only crossing gives `echo` with `echo_irq` held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_in | input | 1 | Asynchronous pulse derived from the AC supply |
| rate_double | input | 1 | 0: tick on rising line edges only; 1: tick on both edges |
| reload_val | input | CNT_W (24) | Countdown value to load |
| reload_stb | input | 1 | Load strobe for `reload_val`; wins over a same-cycle decrement |
| ext_dec | input | 1 | Decrement from a source other than the tick |
| tick_irq | output | 1 | One-cycle timekeeping interrupt request |
| count_o | output | CNT_W (24) | Current signed countdown value |
| echo | output | 1 | One-cycle pulse on a 0-to-minus-1 step |
| echo_irq | output | 1 | One-cycle follow-on interrupt request for a tick-caused crossing |

## Verification
The bench drives falling line edges in single-rate mode, where a design that detects any change would tick twice per period and lose count. It lands a reload strobe on top of a decrement while the count sits at zero. A design that let the decrement win would show -1 and a false echo. It places a tick and an external decrement in the same cycle, which exposes a double decrement or a lost follow-on interrupt. It also steps past -1 and crosses zero from the external source alone, which catch an echo that fires on every negative step and an interrupt raised for a step that no tick caused.

// File: rtl/ltc_pkg.sv
package ltc_pkg;

  typedef enum logic {
    RATE_SINGLE = 1'b0,
    RATE_DOUBLE = 1'b1
  } ltc_rate_e;

  // Decide whether a synchronized line transition is a tick for the rate mode.
  function automatic logic ltc_edge_hit(ltc_rate_e rate, logic cur, logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return (rate == RATE_DOUBLE) ? (rise | fall) : rise;
  endfunction

endpackage

// File: rtl/ltc_rst_sync.sv
module ltc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/ltc_line_edge.sv
module ltc_line_edge
  import ltc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic rate_double,
  output logic tick_now,
  output logic tick_q
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   line_s;
  ltc_rate_e              rate;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= line_in;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign line_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    rate     = ltc_rate_e'(rate_double);
    tick_now = ltc_edge_hit(rate, line_s, prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      prev_q <= line_s;
      tick_q <= tick_now;
    end
  end

endmodule

// File: rtl/ltc_countdown.sv
module ltc_countdown #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_now,
  input  logic             ext_dec,
  input  logic             reload_stb,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count_q,
  output logic             echo_q,
  output logic             echo_irq_q
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic             dec_req;
  logic             at_zero;
  logic             cnt_en;
  logic [CNT_W-1:0] count_d;
  logic             echo_d;
  logic             echo_irq_d;

  always_comb begin
    dec_req    = tick_now | ext_dec;
    at_zero    = (count_q == ZERO);
    cnt_en     = reload_stb | dec_req;
    count_d    = count_q;
    echo_d     = 1'b0;
    echo_irq_d = 1'b0;
    if (reload_stb) begin
      count_d = reload_val;
    end else if (dec_req) begin
      count_d    = count_q - ONE;
      echo_d     = at_zero;
      echo_irq_d = at_zero & tick_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= ZERO;
    end else if (cnt_en) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_q     <= 1'b0;
      echo_irq_q <= 1'b0;
    end else begin
      echo_q     <= echo_d;
      echo_irq_q <= echo_irq_d;
    end
  end

endmodule

// File: rtl/linetick_countdown.sv
module linetick_countdown #(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic             rate_double,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             reload_stb,
  input  logic             ext_dec,
  output logic             tick_irq,
  output logic [CNT_W-1:0] count_o,
  output logic             echo,
  output logic             echo_irq
);

  logic rst_q_n;
  logic tick_now;

  ltc_rst_sync #(
    .STAGES(RST_STAGES)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  ltc_line_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .line_in     (line_in),
    .rate_double (rate_double),
    .tick_now    (tick_now),
    .tick_q      (tick_irq)
  );

  ltc_countdown #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .tick_now   (tick_now),
    .ext_dec    (ext_dec),
    .reload_stb (reload_stb),
    .reload_val (reload_val),
    .count_q    (count_o),
    .echo_q     (echo),
    .echo_irq_q (echo_irq)
  );

endmodule

// File: rtl/ltc_checker.sv
module ltc_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_now,
  input logic             ext_dec,
  input logic             reload_stb,
  input logic [CNT_W-1:0] reload_val,
  input logic             tick_irq,
  input logic [CNT_W-1:0] count_o,
  input logic             echo,
  input logic             echo_irq
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r2_tick_registered: assert property (@(posedge clk) disable iff (!rst_n)
    tick_now |=> tick_irq);

  // R5 and R6: one step down per decrementing cycle
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((tick_now || ext_dec) && !reload_stb) |=> (count_o == ($past(count_o) - ONE)));

  a_r7_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reload_stb |=> (count_o == $past(reload_val)));

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_now && !ext_dec && !reload_stb) |=> $stable(count_o));

  a_r8_echo_at_minus_one: assert property (@(posedge clk) disable iff (!rst_n)
    echo |-> ((count_o == '1) && ($past(count_o) == '0)));

  a_r9_irq_needs_echo: assert property (@(posedge clk) disable iff (!rst_n)
    echo_irq |-> echo);

  a_r9_no_irq_from_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_dec && !tick_now && !reload_stb) |=> !echo_irq);

  a_r7_no_echo_on_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload_stb |=> !echo);

endmodule

bind linetick_countdown ltc_checker #(
  .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .tick_now   (tick_now),
  .ext_dec    (ext_dec),
  .reload_stb (reload_stb),
  .reload_val (reload_val),
  .tick_irq   (tick_irq),
  .count_o    (count_o),
  .echo       (echo),
  .echo_irq   (echo_irq)
);

// File: tb/linetick_countdown_bench.sv
`timescale 1ns/1ps
module linetick_countdown_bench;

  localparam int CNT_W = 24;
  localparam real HALF = 4.0;

  logic             clk;
  logic             rst_n;
  logic             line_in;
  logic             rate_double;
  logic [CNT_W-1:0] reload_val;
  logic             reload_stb;
  logic             ext_dec;
  logic             tick_irq;
  logic [CNT_W-1:0] count_o;
  logic             echo;
  logic             echo_irq;

  int checks;
  int errors;
  bit done;

  linetick_countdown #(.CNT_W(CNT_W)) u_linetick_countdown (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_in     (line_in),
    .rate_double (rate_double),
    .reload_val  (reload_val),
    .reload_stb  (reload_stb),
    .ext_dec     (ext_dec),
    .tick_irq    (tick_irq),
    .count_o     (count_o),
    .echo        (echo),
    .echo_irq    (echo_irq)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  task automatic chk(input string req, input integer act, input integer exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic integer cnt();
    return $signed(count_o);
  endfunction

  // Drive a line level, optionally with ext_dec in the cycle the tick forms.
  // Returns at the negedge after the third posedge, where results are valid.
  task automatic line_to(input logic v, input logic ext_in_tick);
    @(negedge clk) line_in = v;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) ext_dec = ext_in_tick;
    @(posedge clk);
    @(negedge clk) ext_dec = 1'b0;
  endtask

  task automatic reload(input integer v, input logic with_dec);
    @(negedge clk);
    reload_val = v[CNT_W-1:0];
    reload_stb = 1'b1;
    ext_dec    = with_dec;
    @(negedge clk);
    reload_stb = 1'b0;
    ext_dec    = 1'b0;
  endtask

  task automatic ext_pulse();
    @(negedge clk) ext_dec = 1'b1;
    @(negedge clk) ext_dec = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 tick in reset", tick_irq, 0);
    chk("R1 count in reset", cnt(), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 tick after reset", tick_irq, 0);
    chk("R1 echo after reset", echo, 0);
    chk("R1 echo_irq after reset", echo_irq, 0);
    chk("R1 count after reset", cnt(), 0);
  endtask

  task automatic t_single_rate();
    rate_double = 1'b0;
    reload(5, 1'b0);
    chk("R7 reload value", cnt(), 5);
    line_to(1'b1, 1'b0);
    chk("R2 R3 tick on rise", tick_irq, 1);
    chk("R5 count after tick", cnt(), 4);
    @(negedge clk);
    chk("R2 tick lasts one cycle", tick_irq, 0);
    line_to(1'b0, 1'b0);
    chk("R3 no tick on fall", tick_irq, 0);
    repeat (2) @(negedge clk);
    chk("R3 count kept on fall", cnt(), 4);
  endtask

  task automatic t_double_rate();
    rate_double = 1'b1;
    line_to(1'b1, 1'b0);
    chk("R4 tick on rise", tick_irq, 1);
    chk("R4 count after rise", cnt(), 3);
    line_to(1'b0, 1'b0);
    chk("R4 tick on fall", tick_irq, 1);
    chk("R4 count after fall", cnt(), 2);
  endtask

  task automatic t_ext_dec();
    ext_pulse();
    chk("R6 ext decrement", cnt(), 1);
    chk("R8 no echo above zero", echo, 0);
  endtask

  task automatic t_reload_priority();
    reload(9, 1'b1);
    chk("R7 reload beats decrement", cnt(), 9);
    reload(0, 1'b0);
    reload(0, 1'b1);
    chk("R7 reload at zero with decrement", cnt(), 0);
    chk("R7 no echo on reload", echo, 0);
  endtask

  task automatic t_echo_tick();
    reload(0, 1'b0);
    line_to(1'b1, 1'b0);
    chk("R8 count crossed", cnt(), -1);
    chk("R8 echo on crossing", echo, 1);
    chk("R9 echo_irq from tick", echo_irq, 1);
    @(negedge clk);
    chk("R8 echo one cycle", echo, 0);
    chk("R9 echo_irq one cycle", echo_irq, 0);
    line_to(1'b0, 1'b0);
    chk("R8 count below minus one", cnt(), -2);
    chk("R8 no echo below minus one", echo, 0);
  endtask

  task automatic t_echo_ext();
    reload(0, 1'b0);
    ext_pulse();
    chk("R8 ext crossing count", cnt(), -1);
    chk("R8 echo from ext", echo, 1);
    chk("R9 no echo_irq from ext", echo_irq, 0);
  endtask

  task automatic t_same_cycle();
    reload(0, 1'b0);
    line_to(1'b1, 1'b1);
    chk("R6 one step for tick plus ext", cnt(), -1);
    chk("R6 tick seen with ext", tick_irq, 1);
    chk("R9 echo_irq when tick shares cycle", echo_irq, 1);
  endtask

  initial begin
    checks      = 0;
    errors      = 0;
    done        = 1'b0;
    line_in     = 1'b0;
    rate_double = 1'b0;
    reload_val  = '0;
    reload_stb  = 1'b0;
    ext_dec     = 1'b0;
    t_reset();
    t_single_rate();
    t_double_rate();
    t_ext_dec();
    t_reload_priority();
    t_echo_tick();
    t_echo_ext();
    t_same_cycle();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule